// File: doc/BRIEF.md
# Priority DMA Channel Arbiter

This block chooses which of sixteen DMA channel requests the transfer engine serves next. Each channel supplies a request line, a four-bit priority value and a preemption-enable bit. A single mode input selects between fixed-priority and round-robin arbitration. The transfer engine reports two kinds of status back. A pulse on `seq_done_i` marks the end of one read/write sequence. A pulse on `loop_done_i` marks the end of a minor loop, which also releases the channel.

In fixed mode, a higher-priority request can suspend a running channel whose preemption-enable bit is set. The preempting channel then runs to the end of its minor loop. After that, the suspended channel is restored before any other channel is granted. A restored channel cannot be preempted until it finishes one read/write sequence. Only one level of preemption is supported, and one suspended channel is held at a time. When two channels hold the same priority value in fixed mode, a configuration error is raised and no new grants are made.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `grant_vld_o`, `suspend_o` and `resume_o` are 0, and `act_ch_o` is 0.
- R2: In fixed mode (`rr_mode_i`=0) with no grant and no channel suspended, the next clock edge grants the requesting channel with the numerically largest priority. `grant_vld_o` goes to 1 and `act_ch_o` gives that channel's index.
- R3: `cfg_err_o` follows the inputs combinationally. It is 1 when `rr_mode_i`=0 and two or more channels hold equal priority values. Otherwise it is 0.
- R4: While `cfg_err_o` is 1, no new grant or preemption takes place.
- R5: A `loop_done_i` pulse during a grant makes `grant_vld_o` 0 at the next edge. Arbitration happens at the edge after that.
- R6: In fixed mode, a preemption happens at the next edge when all of these hold: the running channel has its preemption-enable bit set, it is neither a preemptor nor a restored channel still waiting for its first sequence, and some requesting channel has a larger priority. At that edge `act_ch_o` switches to the highest-priority requester and `suspend_o` pulses high for one cycle.
- R7: A running channel whose preemption-enable bit is 0 is never suspended.
- R8: A channel granted through preemption cannot itself be preempted.
- R9: When a channel is suspended, the first grant after the preemptor is released restores that suspended channel. This happens whatever requests are pending, and `resume_o` pulses for one cycle.
- R10: A restored channel cannot be preempted until a `seq_done_i` pulse arrives. If a higher-priority request is still pending, the preemption happens at the second edge after that pulse.
- R11: In round-robin mode (`rr_mode_i`=1), an idle arbiter grants the lowest-numbered requesting channel above `act_ch_o`, wrapping from 15 to 0. No preemption happens in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Per-channel request |
| prio_i | input | 64 | Per-channel priority; channel n at bits [4n+3:4n] |
| preempt_en_i | input | 16 | Per-channel preemption enable |
| rr_mode_i | input | 1 | 0 = fixed priority, 1 = round robin |
| seq_done_i | input | 1 | End of one read/write sequence of the active channel |
| loop_done_i | input | 1 | End of minor loop of the active channel; releases it |
| act_ch_o | output | 4 | Active channel index |
| grant_vld_o | output | 1 | A channel is granted |
| suspend_o | output | 1 | One-cycle pulse: running channel was suspended |
| resume_o | output | 1 | One-cycle pulse: suspended channel was restored |
| cfg_err_o | output | 1 | Duplicate priority in fixed mode |

## Verification
The hardest situation to reach is a restored channel being suspended a second time. To get there, the stimulus must preempt a channel, release the preemptor with `loop_done_i`, and keep a higher-priority request pending through the restore. It must then confirm that no suspension happens until `seq_done_i` arrives, and that it does happen one edge later. A directed sequence drives exactly this path. A long random phase then mixes release and sequence pulses, enable bits and mode changes, while a behavioural model tracks the suspended slot every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  parameter int unsigned ARB_NUM_CH = 16;
  parameter int unsigned ARB_PRIO_W = 4;
endpackage

// File: rtl/dma_arb_dup_chk.sv
module dma_arb_dup_chk #(
  parameter int unsigned NUM_CH = dma_arb_pkg::ARB_NUM_CH,
  parameter int unsigned PRIO_W = dma_arb_pkg::ARB_PRIO_W
) (
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic                     dup_o
);
  always_comb begin
    dup_o = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      for (int j = i + 1; j < NUM_CH; j++)
        if (prio_i[i*PRIO_W +: PRIO_W] == prio_i[j*PRIO_W +: PRIO_W]) dup_o = 1'b1;
  end
endmodule

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
  parameter int unsigned NUM_CH = dma_arb_pkg::ARB_NUM_CH,
  parameter int unsigned PRIO_W = dma_arb_pkg::ARB_PRIO_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic                     vld_o,
  output logic [CH_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]        prio_o
);
  // strict compare keeps the lowest index on a tie
  always_comb begin
    vld_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        vld_o  = 1'b1;
        idx_o  = CH_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int unsigned NUM_CH = dma_arb_pkg::ARB_NUM_CH,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [CH_W-1:0]   last_i,
  output logic              vld_o,
  output logic [CH_W-1:0]   idx_o
);
  always_comb begin
    int cand;
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      cand = (int'(last_i) + k) % NUM_CH;
      if (!vld_o && req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = CH_W'(cand);
      end
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned NUM_CH = dma_arb_pkg::ARB_NUM_CH,
  parameter int unsigned PRIO_W = dma_arb_pkg::ARB_PRIO_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH-1:0]        preempt_en_i,
  input  logic                     rr_mode_i,
  input  logic                     seq_done_i,
  input  logic                     loop_done_i,
  output logic [CH_W-1:0]          act_ch_o,
  output logic                     grant_vld_o,
  output logic                     suspend_o,
  output logic                     resume_o,
  output logic                     cfg_err_o
);
  logic              dup;
  logic              fx_vld, rr_vld;
  logic [CH_W-1:0]   fx_idx, rr_idx;
  logic [PRIO_W-1:0] fx_prio, cur_prio;

  logic            busy_q, busy_d;
  logic [CH_W-1:0] act_q, act_d;
  logic            pre_q, pre_d;     // active channel is a preemptor
  logic            rest_q, rest_d;   // restored, awaiting first sequence
  logic            sv_q, sv_d;       // suspended slot valid
  logic [CH_W-1:0] sch_q, sch_d;
  logic            sp_d, rp_d;
  logic            sp_q, rp_q;

  dma_arb_dup_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dup (
    .prio_i (prio_i),
    .dup_o  (dup)
  );

  dma_arb_fixed_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fix (
    .req_i  (req_i),
    .prio_i (prio_i),
    .vld_o  (fx_vld),
    .idx_o  (fx_idx),
    .prio_o (fx_prio)
  );

  dma_arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
    .req_i  (req_i),
    .last_i (act_q),
    .vld_o  (rr_vld),
    .idx_o  (rr_idx)
  );

  assign cfg_err_o = !rr_mode_i && dup;
  assign cur_prio  = prio_i[act_q*PRIO_W +: PRIO_W];

  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    pre_d  = pre_q;
    rest_d = rest_q;
    sv_d   = sv_q;
    sch_d  = sch_q;
    sp_d   = 1'b0;
    rp_d   = 1'b0;
    if (busy_q) begin
      if (loop_done_i) begin
        busy_d = 1'b0;
        pre_d  = 1'b0;
        rest_d = 1'b0;
      end else if (rest_q) begin
        if (seq_done_i) rest_d = 1'b0;
      end else if (!rr_mode_i && !pre_q && !sv_q && !cfg_err_o &&
                   preempt_en_i[act_q] && fx_vld && fx_prio > cur_prio) begin
        sch_d = act_q;
        sv_d  = 1'b1;
        act_d = fx_idx;
        pre_d = 1'b1;
        sp_d  = 1'b1;
      end
    end else if (sv_q) begin
      act_d  = sch_q;
      busy_d = 1'b1;
      sv_d   = 1'b0;
      rest_d = 1'b1;
      rp_d   = 1'b1;
    end else if (rr_mode_i && rr_vld) begin
      act_d  = rr_idx;
      busy_d = 1'b1;
    end else if (!rr_mode_i && !cfg_err_o && fx_vld) begin
      act_d  = fx_idx;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      pre_q  <= 1'b0;
      rest_q <= 1'b0;
      sv_q   <= 1'b0;
      sch_q  <= '0;
      sp_q   <= 1'b0;
      rp_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      act_q  <= act_d;
      pre_q  <= pre_d;
      rest_q <= rest_d;
      sv_q   <= sv_d;
      sch_q  <= sch_d;
      sp_q   <= sp_d;
      rp_q   <= rp_d;
    end
  end

  assign act_ch_o    = act_q;
  assign grant_vld_o = busy_q;
  assign suspend_o   = sp_q;
  assign resume_o    = rp_q;
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int unsigned NUM_CH = dma_arb_pkg::ARB_NUM_CH,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rr_mode_i,
  input logic            loop_done_i,
  input logic [CH_W-1:0] act_ch_o,
  input logic            grant_vld_o,
  input logic            suspend_o,
  input logic            resume_o,
  input logic            cfg_err_o
);
  logic            pend_q;
  logic [CH_W-1:0] prev_act_q, saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      prev_act_q <= '0;
      saved_q    <= '0;
    end else begin
      prev_act_q <= act_ch_o;
      if (suspend_o) begin
        pend_q  <= 1'b1;
        saved_q <= prev_act_q;
      end else if (resume_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  a_r6_suspend_switches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> (grant_vld_o && act_ch_o != prev_act_q));

  a_r8_no_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> !pend_q);

  a_r9_resume_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (pend_q && grant_vld_o && act_ch_o == saved_q));

  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && loop_done_i) |=> !grant_vld_o);

  a_r4_err_blocks_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_vld_o && !pend_q && cfg_err_o) |=> !grant_vld_o);

  a_r11_rr_no_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_mode_i |=> !suspend_o);

  a_r6_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({suspend_o, resume_o}));
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rr_mode_i   (rr_mode_i),
  .loop_done_i (loop_done_i),
  .act_ch_o    (act_ch_o),
  .grant_vld_o (grant_vld_o),
  .suspend_o   (suspend_o),
  .resume_o    (resume_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_dma_prio_arb.sv
`timescale 1ns/1ps
module tb_dma_prio_arb;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N*4-1:0] prio_v;
  logic [N-1:0] pen = '1;
  logic         rr = 1'b0, seqd = 1'b0, loopd = 1'b0;
  logic [3:0]   act;
  logic         gv, sus, res, cerr;

  int prio[N];
  int n_run = 0, n_fail = 0;

  // model state
  bit m_busy, m_pre, m_rest, m_sv, m_sp, m_rp;
  int m_act, m_sch;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) prio_v[i*4 +: 4] = 4'(prio[i]);

  dma_prio_arb dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio_v),
    .preempt_en_i(pen), .rr_mode_i(rr), .seq_done_i(seqd), .loop_done_i(loopd),
    .act_ch_o(act), .grant_vld_o(gv), .suspend_o(sus), .resume_o(res), .cfg_err_o(cerr)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(string tag, int actual, int expected);
    n_run++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  function automatic bit m_dup();
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (prio[i] == prio[j]) return 1;
    return 0;
  endfunction

  function automatic int m_best();  // -1 when none
    int b = -1;
    for (int i = 0; i < N; i++)
      if (req[i] && (b < 0 || prio[i] > prio[b])) b = i;
    return b;
  endfunction

  function automatic int m_next_rr();
    for (int k = 1; k <= N; k++)
      if (req[(m_act + k) % N]) return (m_act + k) % N;
    return -1;
  endfunction

  task automatic model_step();
    bit err = !rr && m_dup();
    int b = m_best();
    int r = m_next_rr();
    m_sp = 0; m_rp = 0;
    if (m_busy) begin
      if (loopd) begin
        m_busy = 0; m_pre = 0; m_rest = 0;
      end else if (m_rest) begin
        if (seqd) m_rest = 0;
      end else if (!rr && !m_pre && !m_sv && !err && pen[m_act] && b >= 0 && prio[b] > prio[m_act]) begin
        m_sch = m_act; m_sv = 1; m_act = b; m_pre = 1; m_sp = 1;
      end
    end else if (m_sv) begin
      m_act = m_sch; m_busy = 1; m_sv = 0; m_rest = 1; m_rp = 1;
    end else if (rr && r >= 0) begin
      m_act = r; m_busy = 1;
    end else if (!rr && !err && b >= 0) begin
      m_act = b; m_busy = 1;
    end
  endtask

  task automatic compare();
    chk("R2 R11 grant_vld", gv, m_busy);
    if (m_busy) chk("R2 R6 R9 R11 act_ch", act, m_act);
    chk("R6 suspend", sus, m_sp);
    chk("R9 resume", res, m_rp);
    chk("R3 cfg_err", cerr, !rr && m_dup());
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    for (int i = 0; i < N; i++) prio[i] = i;
    m_busy = 0; m_act = 0; m_pre = 0; m_rest = 0; m_sv = 0; m_sch = 0;
    repeat (3) @(negedge clk);
    chk("R1 grant_vld", gv, 0);
    chk("R1 act_ch", act, 0);
    chk("R1 suspend", sus, 0);
    chk("R1 resume", res, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: preempt, restore, re-preempt after one sequence
    req = 16'h0008; cyc();
    chk("R2 grant ch3", act, 3);
    req = 16'h0208; cyc();
    chk("R6 preempt to ch9", act, 9); chk("R6 suspend pulse", sus, 1);
    req = 16'h1208; cyc();
    chk("R8 preemptor kept", act, 9); chk("R8 no suspend", sus, 0);
    loopd = 1; req = 16'h1008; cyc();
    chk("R5 released", gv, 0);
    loopd = 0; cyc();
    chk("R9 restore ch3", act, 3); chk("R9 resume pulse", res, 1);
    cyc(); chk("R10 not preempted yet", act, 3);
    cyc(); chk("R10 still ch3", act, 3);
    seqd = 1; cyc(); chk("R10 seq edge keeps ch3", act, 3);
    seqd = 0; cyc();
    chk("R10 re-preempt ch12", act, 12); chk("R10 suspend pulse", sus, 1);
    loopd = 1; req = 16'h0008; cyc();
    loopd = 0; cyc(); chk("R9 second restore", act, 3);
    seqd = 1; cyc(); seqd = 0;
    pen[3] = 0; req = 16'h1008; cyc(); chk("R7 no preempt", act, 3);
    cyc(); chk("R7 still ch3", act, 3); chk("R7 no suspend", sus, 0);
    pen[3] = 1;
    prio[12] = 3; #1;
    chk("R3 dup flagged", cerr, 1);
    loopd = 1; cyc(); loopd = 0;
    cyc(); cyc(); chk("R4 no grant on error", gv, 0);
    rr = 1; #1; chk("R3 clear in rr", cerr, 0);
    cyc(); chk("R11 rr after ch3", act, 12);
    loopd = 1; cyc(); loopd = 0;
    cyc(); chk("R11 rr wrap", act, 3);
    loopd = 1; cyc(); loopd = 0; req = '0; rr = 0;
    for (int i = 0; i < N; i++) prio[i] = (i * 7) % N;
    cyc();

    // random: unique priorities, mixed mode
    for (int t = 0; t < 6000; t++) begin
      req   = N'($urandom) & N'($urandom);
      loopd = ($urandom % 6) == 0;
      seqd  = ($urandom % 4) == 0;
      if (t % 64 == 0) pen = N'($urandom);
      if (t % 500 == 0) rr = (t % 1500) == 1000;
      if (t == 4000) prio[5] = prio[9];
      if (t == 4600) prio[5] = (5 * 7) % N;
      cyc();
    end
    summary();
  end
endmodule